// File: doc/BRIEF.md
# Extended Stack Pointer and Index Register Slice

This block holds the 16-bit stack pointer and the 16-bit X index register of an 8-bit-compatible processor core whose registers have been widened. It carries out the two register transfers between them, moves the stack pointer on a push or a pull, and presents the memory address for that stack access. A size-prefix flag selects whether a transfer moves 8 or 16 bits. A swap-prefix strobe exchanges the two registers, so that X-indexed addressing modes can address the stack directly.

In 8-bit code the stack stays compatible with the classic machine. A narrow transfer into the stack pointer places it in page one, and while it stays there pushes and pulls wrap inside that 256-byte page. A wide transfer can place the stack pointer anywhere. Outside page one, pushes and pulls move through the whole 16-bit space, and a borrow or carry propagates into the high byte. The decoder upstream raises one operation strobe per instruction step. If several strobes arrive together, a fixed priority picks one of them.

Top module: `ext_stack_regs`

## Requirements
- R1: After reset, S reads 0x01FF and X reads 0x0000.
- R2: A transfer of S to X without the size prefix loads X with {0x00, S[7:0]}. The upper byte of X is cleared.
- R3: A transfer of S to X with the size prefix copies all 16 bits of S into X.
- R4: A transfer of X to S without the size prefix loads S with {0x01, X[7:0]}. This places the stack in page one.
- R5: A transfer of X to S with the size prefix copies all 16 bits of X into S.
- R6: In a push cycle, stackAddr equals the current S, and S is decremented at the following edge. When S[15:8] is 0x01, the decrement wraps inside the page, so 0x0100 becomes 0x01FF.
- R7: In a pull cycle, stackAddr equals the incremented S, and S takes that value at the following edge. When S[15:8] is 0x01, the increment wraps inside the page, so 0x01FF becomes 0x0100.
- R8: When S[15:8] is not 0x01, a push or a pull moves S by one modulo 2^16 and carries into the high byte. For example, a push takes 0x2000 to 0x1FFF, and a pull takes 0xFFFF to 0x0000.
- R9: A swap exchanges S and X in one cycle. A second swap restores both registers.
- R10: When xWrEn is high, X is loaded with all 16 bits of xWrData.
- R11: When several strobes are asserted together, only the highest-priority one acts. The order is swap, then X-to-S, then S-to-X, then X load, then push, then pull. The other strobes have no effect on S or X.
- R12: When neither push nor pull acts, stackAddr equals S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opTsx | input | 1 | Copy S into X |
| opTxs | input | 1 | Copy X into S |
| opPush | input | 1 | Push step: address at S, then decrement |
| opPull | input | 1 | Pull step: increment, then address |
| sizePfx | input | 1 | Size prefix: transfers move 16 bits |
| swapPfx | input | 1 | Swap prefix: exchange S and X |
| xWrEn | input | 1 | Load X from xWrData |
| xWrData | input | 16 | Write data for X |
| sReg | output | 16 | Current stack pointer |
| xReg | output | 16 | Current index register |
| stackAddr | output | 16 | Memory address of the stack access |

## Verification
The assertions rely on the control stage handing the datapath at most one action per cycle. They also rely on the page test being taken on the value of S before the edge. The priority logic guarantees the first condition even when the bench deliberately asserts several strobes at once. The bench drives inputs only at the falling edge, so every strobe combination is stable across a rising edge. It checks directed corner cases, including both page-one wrap points, the 16-bit carry and borrow boundaries, and collisions between strobes. It then runs a long pseudo-random sequence of operations, compared every cycle against a behavioural model.

// File: rtl/ext_stack_pkg.sv
package ext_stack_pkg;
  typedef struct packed {
    logic doSwap;
    logic doTxs;
    logic doTsx;
    logic doXld;
    logic doPush;
    logic doPull;
    logic wide;
  } stackOp_t;
endpackage

// File: rtl/ext_stack_ctrl.sv
module ext_stack_ctrl
  import ext_stack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opTsx,
  input  logic     opTxs,
  input  logic     opPush,
  input  logic     opPull,
  input  logic     sizePfx,
  input  logic     swapPfx,
  input  logic     xWrEn,
  output stackOp_t op
);
  localparam int NumReq = 6;
  logic [NumReq-1:0] req;
  logic [NumReq-1:0] grant;

  // index 0 is the highest priority
  assign req = {opPull, opPush, xWrEn, opTsx, opTxs, swapPfx};

  always_comb begin
    grant = '0;
    for (int i = 0; i < NumReq; i++) begin
      if (req[i] && grant == '0) grant[i] = 1'b1;
    end
  end

  always_comb begin
    op.doSwap = grant[0];
    op.doTxs  = grant[1];
    op.doTsx  = grant[2];
    op.doXld  = grant[3];
    op.doPush = grant[4];
    op.doPull = grant[5];
    op.wide   = sizePfx;
  end

  // R11
  single_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({op.doSwap, op.doTxs, op.doTsx, op.doXld, op.doPush, op.doPull}));

  // R11
  swap_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapPfx |-> (op.doSwap && !op.doPush && !op.doPull));
endmodule

// File: rtl/ext_stack_dp.sv
module ext_stack_dp
  import ext_stack_pkg::*;
#(
  parameter int AddrW     = 16,
  parameter int PageW     = 8,
  parameter int StackPage = 1,
  parameter int ResetLow  = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackOp_t         op,
  input  logic [AddrW-1:0] xWrData,
  output logic [AddrW-1:0] sReg,
  output logic [AddrW-1:0] xReg,
  output logic [AddrW-1:0] stackAddr
);
  localparam int HiW = AddrW - PageW;
  localparam logic [HiW-1:0]   PageHi  = HiW'(StackPage);
  localparam logic [AddrW-1:0] SReset  = {PageHi, PageW'(ResetLow)};

  logic [AddrW-1:0] sQ, xQ, sNext, xNext;
  logic [AddrW-1:0] downAddr, upAddr;
  logic             inPage;

  assign inPage = (sQ[AddrW-1:PageW] == PageHi);

  always_comb begin
    if (inPage) begin
      downAddr = {PageHi, sQ[PageW-1:0] - PageW'(1)};
      upAddr   = {PageHi, sQ[PageW-1:0] + PageW'(1)};
    end else begin
      downAddr = sQ - AddrW'(1);
      upAddr   = sQ + AddrW'(1);
    end
  end

  always_comb begin
    sNext = sQ;
    xNext = xQ;
    if (op.doSwap) begin
      sNext = xQ;
      xNext = sQ;
    end else if (op.doTxs) begin
      sNext = op.wide ? xQ : {PageHi, xQ[PageW-1:0]};
    end else if (op.doTsx) begin
      xNext = op.wide ? sQ : {{HiW{1'b0}}, sQ[PageW-1:0]};
    end else if (op.doXld) begin
      xNext = xWrData;
    end else if (op.doPush) begin
      sNext = downAddr;
    end else if (op.doPull) begin
      sNext = upAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sQ <= SReset;
      xQ <= '0;
    end else begin
      sQ <= sNext;
      xQ <= xNext;
    end
  end

  assign sReg      = sQ;
  assign xReg      = xQ;
  assign stackAddr = op.doPull ? upAddr : sQ;

  // R9
  swap_exchange_chk: assert property (@(posedge clk) disable iff (!rstN)
    op.doSwap |=> (sQ == $past(xQ) && xQ == $past(sQ)));

  // R6
  page_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op.doPush && inPage) |=> (sQ[AddrW-1:PageW] == PageHi));

  // R8
  wide_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op.doPush && !inPage) |=> (sQ == $past(sQ) - AddrW'(1)));

  // R7
  pull_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    op.doPull |=> (sQ == $past(stackAddr)));

  // R2
  tsx_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op.doTsx && !op.wide) |=> (xQ[AddrW-1:PageW] == '0));

  // R4
  txs_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op.doTxs && !op.wide) |=> (sQ[AddrW-1:PageW] == PageHi));
endmodule

// File: rtl/ext_stack_regs.sv
module ext_stack_regs
  import ext_stack_pkg::*;
#(
  parameter int AddrW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opTsx,
  input  logic             opTxs,
  input  logic             opPush,
  input  logic             opPull,
  input  logic             sizePfx,
  input  logic             swapPfx,
  input  logic             xWrEn,
  input  logic [AddrW-1:0] xWrData,
  output logic [AddrW-1:0] sReg,
  output logic [AddrW-1:0] xReg,
  output logic [AddrW-1:0] stackAddr
);
  stackOp_t op;

  ext_stack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opTsx(opTsx), .opTxs(opTxs),
    .opPush(opPush), .opPull(opPull), .sizePfx(sizePfx),
    .swapPfx(swapPfx), .xWrEn(xWrEn), .op(op)
  );

  ext_stack_dp #(.AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .xWrData(xWrData),
    .sReg(sReg), .xReg(xReg), .stackAddr(stackAddr)
  );
endmodule

// File: tb/test_ext_stack_regs.sv
module test_ext_stack_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opTsx = 0, opTxs = 0, opPush = 0, opPull = 0;
  logic sizePfx = 0, swapPfx = 0, xWrEn = 0;
  logic [15:0] xWrData = '0;
  logic [15:0] sReg, xReg, stackAddr;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;
  int mS, mX;

  always #2 clk = ~clk;

  ext_stack_regs i_ext_stack_regs (
    .clk(clk), .rstN(rstN), .opTsx(opTsx), .opTxs(opTxs),
    .opPush(opPush), .opPull(opPull), .sizePfx(sizePfx),
    .swapPfx(swapPfx), .xWrEn(xWrEn), .xWrData(xWrData),
    .sReg(sReg), .xReg(xReg), .stackAddr(stackAddr)
  );

  task automatic check(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%04h expected=%04h", req, what, act, exp);
    end
  endtask

  function automatic int stepDown(int s);
    if (s / 256 == 1) return 256 + ((s % 256) + 255) % 256;
    return (s + 65535) % 65536;
  endfunction

  function automatic int stepUp(int s);
    if (s / 256 == 1) return 256 + ((s % 256) + 1) % 256;
    return (s + 1) % 65536;
  endfunction

  // one cycle: drive at negedge, check address, model edge, compare state
  task automatic cyc(string req, bit sw, bit txs, bit tsx, bit xl, bit pu, bit pl,
                     bit wide, int data);
    int expAddr, t;
    swapPfx = sw; opTxs = txs; opTsx = tsx; xWrEn = xl;
    opPush = pu; opPull = pl; sizePfx = wide; xWrData = 16'(data);
    #1;
    expAddr = mS;
    if (!sw && !txs && !tsx && !xl && !pu && pl) expAddr = stepUp(mS);
    check(req, "stackAddr", int'(stackAddr), expAddr);
    @(posedge clk);
    if (sw) begin t = mS; mS = mX; mX = t; end
    else if (txs) mS = wide ? mX : 256 + (mX % 256);
    else if (tsx) mX = wide ? mS : (mS % 256);
    else if (xl)  mX = data % 65536;
    else if (pu)  mS = stepDown(mS);
    else if (pl)  mS = stepUp(mS);
    @(negedge clk);
    check(req, "S", int'(sReg), mS);
    check(req, "X", int'(xReg), mX);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    mS = 16'h01FF; mX = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "S", int'(sReg), 16'h01FF);
    check("R1", "X", int'(xReg), 0);
    // R6 pushes inside page one, R12 idle address
    cyc("R6", 0,0,0,0,1,0,0,0);
    cyc("R6", 0,0,0,0,1,0,0,0);
    cyc("R7", 0,0,0,0,0,1,0,0);
    cyc("R12", 0,0,0,0,0,0,0,0);
    // R2 narrow S->X, after a wide X load to prove upper byte clears
    cyc("R10", 0,0,0,1,0,0,0,16'hBEEF);
    cyc("R2", 0,0,1,0,0,0,0,0);
    // R4 narrow X->S
    cyc("R10", 0,0,0,1,0,0,0,16'h1234);
    cyc("R4", 0,1,0,0,0,0,0,0);
    // R6 page wrap 0100 -> 01FF, R7 01FF -> 0100
    cyc("R10", 0,0,0,1,0,0,0,16'hAB00);
    cyc("R4", 0,1,0,0,0,0,0,0);
    cyc("R6", 0,0,0,0,1,0,0,0);
    cyc("R7", 0,0,0,0,0,1,0,0);
    // R5 wide X->S, R8 carries outside page one
    cyc("R10", 0,0,0,1,0,0,0,16'h2000);
    cyc("R5", 0,1,0,0,0,0,1,0);
    cyc("R8", 0,0,0,0,1,0,0,0);
    cyc("R8", 0,0,0,0,0,1,0,0);
    cyc("R10", 0,0,0,1,0,0,0,16'h0000);
    cyc("R5", 0,1,0,0,0,0,1,0);
    cyc("R8", 0,0,0,0,1,0,0,0);
    cyc("R8", 0,0,0,0,0,1,0,0);
    cyc("R8", 0,0,0,0,0,1,0,0);
    // R3 wide S->X
    cyc("R10", 0,0,0,1,0,0,0,16'h5A5A);
    cyc("R5", 0,1,0,0,0,0,1,0);
    cyc("R10", 0,0,0,1,0,0,0,16'h0011);
    cyc("R3", 0,0,1,0,0,0,1,0);
    // R9 swap twice
    cyc("R10", 0,0,0,1,0,0,0,16'hC3C3);
    cyc("R9", 1,0,0,0,0,0,0,0);
    cyc("R9", 1,0,0,0,0,0,0,0);
    // R11 collisions
    cyc("R11", 1,0,0,0,1,1,0,0);
    cyc("R11", 0,1,1,0,0,0,0,0);
    cyc("R11", 0,0,1,1,0,0,1,16'h7777);
    cyc("R11", 0,0,0,1,1,0,0,16'h0F0F);
    cyc("R11", 0,0,0,0,1,1,0,0);
    // random mix against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R11", lfsr[0] & lfsr[7] & lfsr[9], lfsr[1] & lfsr[8], lfsr[2] & lfsr[11],
          lfsr[3] & lfsr[6], lfsr[4], lfsr[5], lfsr[12], int'({lfsr[7:0], lfsr[15:8]}));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule